// File: doc/BRIEF.md
# NaN-Boxing Floating-Point Register File

This block is the floating-point register file of a core whose registers are 64 bits wide. It also holds half-precision and single-precision values. A narrow value sits in the low bits of a register, and every bit above it is set to 1. A value stored this way, viewed as any wider format, looks like a negative quiet NaN. The file has 32 registers, one write port and two read ports.

The write port carries a format selector. A narrow write keeps the low 16 or 32 bits of the write data and fills the rest of the register with ones. A double write stores all 64 bits.

Each read port also carries a format selector and a mode bit.
- **Transfer mode** serves stores and moves to integer registers. It returns the low bits of the register and ignores the upper bits.
- **Compute mode** serves arithmetic operands. It first checks the box. A badly boxed narrow operand is replaced by the canonical NaN of its format, and the port raises a failure flag.

Reads are combinational. Writes land on the clock edge, and there is no bypass from the write port to the read ports.

Top module: `fpbox_regfile`

## Requirements
- R1: When reset is asserted, every register becomes 0. After reset, a double-format read of any register returns 0 with the failure flag low.
- R2: The format encodings are 00 = half (16 bits), 01 = single (32 bits), 10 = double (64 bits), and 11 = treated as double.
  - A half write stores {48 ones, wr_data[15:0]}.
  - A single write stores {32 ones, wr_data[31:0]}.
  - A double write stores wr_data unchanged.
  - On a narrow write, the upper bits of wr_data have no effect.
- R3: In transfer mode (rd_cmp = 0), a half read returns the stored bits [15:0] and a single read returns the stored bits [31:0]. Both are zero-extended to 64 bits, whatever the upper stored bits hold. The failure flag stays low.
- R4: In compute mode (rd_cmp = 1), a narrow read whose upper register bits are all ones returns the low 16 or 32 bits, zero-extended, with the failure flag low.
- R5: In compute mode, a narrow read where any upper register bit is 0 returns the canonical NaN, zero-extended, and raises the failure flag. The canonical NaN is 0x7E00 for half and 0x7FC00000 for single. A register holding 0 after reset takes this path.
- R6: A double-format read (format 10 or 11) in either mode returns all 64 stored bits with the failure flag low.
- R7: A write is visible from the rising clock edge that accepts it. A read of the written register in the same cycle as the write returns the old contents, because there is no bypass.
- R8: A correctly boxed half value, read as single or as double, has its sign bit set, all exponent bits set and the top mantissa bit set. It is therefore a negative quiet NaN. A boxed single value read as double has the same property.
- R9: The two read ports are independent. Each one decodes its own address, format and mode in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; its release is synchronised inside the block |
| wr_en | input | 1 | Write enable |
| wr_addr | input | 5 | Write register index |
| wr_fmt | input | 2 | Write format (00 half, 01 single, 10/11 double) |
| wr_data | input | 64 | Write value; a narrow value sits in the low bits |
| rd_addr | input | 2x5 | Read register index, one per port |
| rd_fmt | input | 2x2 | Read format, one per port |
| rd_cmp | input | 2 | Read mode per port: 1 = compute operand, 0 = transfer |
| rd_data | output | 2x64 | Read result, one per port |
| rd_nanfail | output | 2 | Per port: a canonical NaN replaced a badly boxed compute operand |

## Verification
The read results are combinational, so every read result is due in the same cycle as its address, format and mode. The bench drives those inputs on the falling edge and samples the scoreboard 3 ns later, before the next rising edge. A write is accepted at the rising edge that follows the falling edge on which it was driven. A read driven together with the write must therefore still show the old contents, and the same read on the next falling edge must show the new contents. The bench keeps its reference model one cycle behind the driven write so that its expected values follow this timing. After reset is released, the release takes two rising edges to pass through the synchroniser, so the bench waits before its first access.

// File: rtl/fpbox_pkg.sv
package fpbox_pkg;
  typedef enum logic [1:0] {
    FMT_HALF   = 2'b00,
    FMT_SINGLE = 2'b01,
    FMT_DOUBLE = 2'b10,
    FMT_WIDE   = 2'b11
  } fpfmt_e;

  localparam int HALF_W   = 16;
  localparam int SINGLE_W = 32;
  localparam logic [HALF_W-1:0]   CANON_HALF   = 16'h7E00;
  localparam logic [SINGLE_W-1:0] CANON_SINGLE = 32'h7FC0_0000;
endpackage

// File: rtl/fpbox_rst_sync.sv
module fpbox_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/fpbox_box.sv
module fpbox_box
  import fpbox_pkg::*;
#(
  parameter int FLEN = 64
) (
  input  logic [1:0]      fmt,
  input  logic [FLEN-1:0] din,
  output logic [FLEN-1:0] boxed
);
  localparam int HPAD = FLEN - HALF_W;
  localparam int SPAD = FLEN - SINGLE_W;

  always_comb begin
    unique case (fpfmt_e'(fmt))
      FMT_HALF:   boxed = {{HPAD{1'b1}}, din[HALF_W-1:0]};
      FMT_SINGLE: boxed = {{SPAD{1'b1}}, din[SINGLE_W-1:0]};
      default:    boxed = din;
    endcase
  end
endmodule

// File: rtl/fpbox_store.sv
module fpbox_store #(
  parameter int FLEN = 64,
  parameter int NREG = 32,
  parameter int NRD  = 2,
  localparam int AW  = $clog2(NREG)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     we,
  input  logic [AW-1:0]            waddr,
  input  logic [FLEN-1:0]          wval,
  input  logic [NRD-1:0][AW-1:0]   raddr,
  output logic [NRD-1:0][FLEN-1:0] rval
);
  logic [FLEN-1:0] ent [NREG];

  for (genvar i = 0; i < NREG; i++) begin : g_ent
    logic            en;
    logic [FLEN-1:0] d;
    logic [FLEN-1:0] q;

    always_comb begin
      en = we && (waddr == AW'(i));
      d  = wval;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (en) q <= d;
    end

    assign ent[i] = q;
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    always_comb begin
      rval[p] = ent[raddr[p]];
    end
  end
endmodule

// File: rtl/fpbox_unbox.sv
module fpbox_unbox
  import fpbox_pkg::*;
#(
  parameter int FLEN = 64
) (
  input  logic [1:0]      fmt,
  input  logic            cmp,
  input  logic [FLEN-1:0] raw,
  output logic [FLEN-1:0] dout,
  output logic            fail
);
  localparam int HPAD = FLEN - HALF_W;
  localparam int SPAD = FLEN - SINGLE_W;

  logic half_ok;
  logic single_ok;

  always_comb begin
    half_ok   = &raw[FLEN-1:HALF_W];
    single_ok = &raw[FLEN-1:SINGLE_W];
    fail      = 1'b0;
    unique case (fpfmt_e'(fmt))
      FMT_HALF: begin
        if (cmp && !half_ok) begin
          dout = {{HPAD{1'b0}}, CANON_HALF};
          fail = 1'b1;
        end else begin
          dout = {{HPAD{1'b0}}, raw[HALF_W-1:0]};
        end
      end
      FMT_SINGLE: begin
        if (cmp && !single_ok) begin
          dout = {{SPAD{1'b0}}, CANON_SINGLE};
          fail = 1'b1;
        end else begin
          dout = {{SPAD{1'b0}}, raw[SINGLE_W-1:0]};
        end
      end
      default: dout = raw;
    endcase
  end
endmodule

// File: rtl/fpbox_regfile.sv
module fpbox_regfile #(
  parameter int FLEN = 64,
  parameter int NREG = 32,
  parameter int NRD  = 2,
  localparam int AW  = $clog2(NREG)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [AW-1:0]            wr_addr,
  input  logic [1:0]               wr_fmt,
  input  logic [FLEN-1:0]          wr_data,
  input  logic [NRD-1:0][AW-1:0]   rd_addr,
  input  logic [NRD-1:0][1:0]      rd_fmt,
  input  logic [NRD-1:0]           rd_cmp,
  output logic [NRD-1:0][FLEN-1:0] rd_data,
  output logic [NRD-1:0]           rd_nanfail
);
  logic                     rst_sync_n;
  logic [FLEN-1:0]          wr_boxed;
  logic [NRD-1:0][FLEN-1:0] raw_val;

  fpbox_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  fpbox_box #(.FLEN(FLEN)) u_box (
    .fmt   (wr_fmt),
    .din   (wr_data),
    .boxed (wr_boxed)
  );

  fpbox_store #(.FLEN(FLEN), .NREG(NREG), .NRD(NRD)) u_store (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .we    (wr_en),
    .waddr (wr_addr),
    .wval  (wr_boxed),
    .raddr (rd_addr),
    .rval  (raw_val)
  );

  for (genvar p = 0; p < NRD; p++) begin : g_port
    fpbox_unbox #(.FLEN(FLEN)) u_unbox (
      .fmt  (rd_fmt[p]),
      .cmp  (rd_cmp[p]),
      .raw  (raw_val[p]),
      .dout (rd_data[p]),
      .fail (rd_nanfail[p])
    );
  end
endmodule

// File: rtl/fpbox_regfile_chk.sv
module fpbox_regfile_chk #(
  parameter int FLEN = 64,
  parameter int NREG = 32,
  parameter int NRD  = 2,
  localparam int AW  = $clog2(NREG)
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     wr_en,
  input logic [AW-1:0]            wr_addr,
  input logic [1:0]               wr_fmt,
  input logic [FLEN-1:0]          wr_data,
  input logic [NRD-1:0][AW-1:0]   rd_addr,
  input logic [NRD-1:0][1:0]      rd_fmt,
  input logic [NRD-1:0]           rd_cmp,
  input logic [NRD-1:0][FLEN-1:0] rd_data,
  input logic [NRD-1:0]           rd_nanfail
);
  for (genvar p = 0; p < NRD; p++) begin : g_p
    AST_FLAG_NEEDS_NARROW_COMPUTE: assert property (@(posedge clk) disable iff (!rst_n)
      rd_nanfail[p] |-> (rd_cmp[p] && !rd_fmt[p][1])); // R5
    AST_HALF_FAIL_CANON: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_nanfail[p] && rd_fmt[p] == 2'b00) |-> (rd_data[p] == 64'h7E00)); // R5
    AST_SINGLE_FAIL_CANON: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_nanfail[p] && rd_fmt[p] == 2'b01) |-> (rd_data[p] == 64'h7FC0_0000)); // R5
    AST_XFER_HALF_ZERO_EXT: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd_cmp[p] && rd_fmt[p] == 2'b00) |-> (rd_data[p][FLEN-1:16] == '0 && !rd_nanfail[p])); // R3
    AST_DOUBLE_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      rd_fmt[p][1] |-> !rd_nanfail[p]); // R6
    AST_WRITE_VISIBLE: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(wr_en) && $past(wr_fmt) == 2'b10 && rd_fmt[p] == 2'b10 &&
       rd_addr[p] == $past(wr_addr)) |-> (rd_data[p] == $past(wr_data))); // R7
    AST_HALF_BOXED: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(wr_en) && $past(wr_fmt) == 2'b00 && rd_fmt[p] == 2'b10 &&
       rd_addr[p] == $past(wr_addr)) |-> (&rd_data[p][FLEN-1:16])); // R2
  end
endmodule

bind fpbox_regfile fpbox_regfile_chk #(.FLEN(FLEN), .NREG(NREG), .NRD(NRD)) u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .wr_en      (wr_en),
  .wr_addr    (wr_addr),
  .wr_fmt     (wr_fmt),
  .wr_data    (wr_data),
  .rd_addr    (rd_addr),
  .rd_fmt     (rd_fmt),
  .rd_cmp     (rd_cmp),
  .rd_data    (rd_data),
  .rd_nanfail (rd_nanfail)
);

// File: tb/sim_fpbox_regfile.sv
`timescale 1ns/1ps
module sim_fpbox_regfile;
  logic              clk = 1'b0;
  logic              rst_n;
  logic              wr_en;
  logic [4:0]        wr_addr;
  logic [1:0]        wr_fmt;
  logic [63:0]       wr_data;
  logic [1:0][4:0]   rd_addr;
  logic [1:0][1:0]   rd_fmt;
  logic [1:0]        rd_cmp;
  logic [1:0][63:0]  rd_data;
  logic [1:0]        rd_nanfail;

  always #5 clk = ~clk;

  fpbox_regfile u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_fmt(wr_fmt),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_fmt(rd_fmt), .rd_cmp(rd_cmp),
    .rd_data(rd_data), .rd_nanfail(rd_nanfail)
  );

  typedef struct {
    int          port;
    logic [63:0] d;
    logic        f;
    string       req;
  } item_t;

  item_t       sb[$];
  int          n_cmp = 0;
  int          n_bad = 0;
  bit          done  = 0;
  logic [63:0] model [32];
  bit          pend;
  logic [4:0]  pa;
  logic [1:0]  pf;
  logic [63:0] pd;

  function automatic logic [63:0] box_of(logic [1:0] f, logic [63:0] v);
    if (f == 2'b00)      return {48'hFFFF_FFFF_FFFF, v[15:0]};
    else if (f == 2'b01) return {32'hFFFF_FFFF, v[31:0]};
    else                 return v;
  endfunction

  task automatic exp_of(input logic [63:0] v, input logic [1:0] f, input logic c,
                        output logic [63:0] d, output logic fl);
    fl = 1'b0;
    if (f == 2'b00) begin
      if (c && v[63:16] != 48'hFFFF_FFFF_FFFF) begin d = 64'h7E00; fl = 1'b1; end
      else d = {48'h0, v[15:0]};
    end else if (f == 2'b01) begin
      if (c && v[63:32] != 32'hFFFF_FFFF) begin d = 64'h7FC0_0000; fl = 1'b1; end
      else d = {32'h0, v[31:0]};
    end else d = v;
  endtask

  task automatic cyc();
    @(negedge clk);
    if (pend) begin model[pa] = box_of(pf, pd); pend = 0; end
    wr_en = 1'b0;
  endtask

  task automatic do_wr(input logic [4:0] a, input logic [1:0] f, input logic [63:0] d);
    wr_en = 1'b1; wr_addr = a; wr_fmt = f; wr_data = d;
    pend = 1; pa = a; pf = f; pd = d;
  endtask

  task automatic rd_lit(input int p, input logic [4:0] a, input logic [1:0] f, input logic c,
                        input logic [63:0] ed, input logic ef, input string req);
    item_t it;
    rd_addr[p] = a; rd_fmt[p] = f; rd_cmp[p] = c;
    it.port = p; it.d = ed; it.f = ef; it.req = req;
    sb.push_back(it);
  endtask

  task automatic rd_mod(input int p, input logic [4:0] a, input logic [1:0] f, input logic c,
                        input string req);
    logic [63:0] ed;
    logic        ef;
    exp_of(model[a], f, c, ed, ef);
    rd_lit(p, a, f, c, ed, ef, req);
  endtask

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Scoreboard monitor: results are combinational, sampled 3 ns after the driving edge
  initial begin
    forever begin
      @(negedge clk);
      #3;
      while (sb.size() > 0) begin
        item_t it;
        it = sb.pop_front();
        chk(rd_data[it.port] == it.d, {it.req, " data"}, rd_data[it.port], it.d);
        chk(rd_nanfail[it.port] == it.f, {it.req, " flag"}, 64'(rd_nanfail[it.port]), 64'(it.f));
      end
    end
  end

  initial begin
    #2_000_000;
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    pend = 0;
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_fmt = '0; wr_data = '0;
    rd_addr = '0; rd_fmt = '0; rd_cmp = '0;
    for (int i = 0; i < 32; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) cyc();

    // R1: every register reads zero after reset
    for (int i = 0; i < 32; i += 2) begin
      cyc();
      rd_lit(0, 5'(i), 2'b10, 1'b0, 64'h0, 1'b0, "R1");
      rd_lit(1, 5'(i + 1), 2'b10, 1'b1, 64'h0, 1'b0, "R1");
    end

    // R5: zero register fails the box check in compute mode
    cyc();
    rd_lit(0, 5'd5, 2'b00, 1'b1, 64'h7E00, 1'b1, "R5 half zero");
    rd_lit(1, 5'd5, 2'b01, 1'b1, 64'h7FC0_0000, 1'b1, "R5 single zero");
    cyc();
    rd_lit(0, 5'd5, 2'b00, 1'b0, 64'h0, 1'b0, "R3 half xfer zero");
    rd_lit(1, 5'd5, 2'b01, 1'b0, 64'h0, 1'b0, "R3 single xfer zero");

    // R7/R2: half write with junk upper bits, old value seen in same cycle
    cyc();
    do_wr(5'd1, 2'b00, 64'h1234_5678_9ABC_3C00);
    rd_lit(0, 5'd1, 2'b10, 1'b0, 64'h0, 1'b0, "R7 no bypass");
    cyc();
    rd_lit(0, 5'd1, 2'b10, 1'b0, 64'hFFFF_FFFF_FFFF_3C00, 1'b0, "R2 half boxed");
    rd_lit(1, 5'd1, 2'b00, 1'b1, 64'h3C00, 1'b0, "R4 half compute");
    #3;
    chk(rd_data[0][63] && (&rd_data[0][62:52]) && rd_data[0][51], "R8 half as double qNaN",
        rd_data[0], 64'hFFFF_FFFF_FFFF_3C00);
    cyc();
    rd_lit(0, 5'd1, 2'b01, 1'b1, 64'hFFFF_3C00, 1'b0, "R8 half as single");
    rd_lit(1, 5'd1, 2'b00, 1'b0, 64'h3C00, 1'b0, "R3 half xfer");
    #3;
    chk(rd_data[0][31] && (&rd_data[0][30:23]) && rd_data[0][22], "R8 half as single qNaN",
        rd_data[0], 64'hFFFF_3C00);

    // single write
    cyc();
    do_wr(5'd2, 2'b01, 64'hDEAD_BEEF_3F80_0000);
    cyc();
    rd_lit(0, 5'd2, 2'b00, 1'b1, 64'h7E00, 1'b1, "R5 single as half");
    rd_lit(1, 5'd2, 2'b01, 1'b1, 64'h3F80_0000, 1'b0, "R4 single compute");
    cyc();
    rd_lit(0, 5'd2, 2'b10, 1'b1, 64'hFFFF_FFFF_3F80_0000, 1'b0, "R8 single boxed as double");
    rd_lit(1, 5'd2, 2'b00, 1'b0, 64'h0000, 1'b0, "R3 single xfer half");
    #3;
    chk(rd_data[0][63] && (&rd_data[0][62:52]) && rd_data[0][51], "R8 single as double qNaN",
        rd_data[0], 64'hFFFF_FFFF_3F80_0000);

    // double write
    cyc();
    do_wr(5'd3, 2'b10, 64'h4009_21FB_5444_2D18);
    cyc();
    rd_lit(0, 5'd3, 2'b01, 1'b1, 64'h7FC0_0000, 1'b1, "R5 double as single");
    rd_lit(1, 5'd3, 2'b01, 1'b0, 64'h5444_2D18, 1'b0, "R3 single xfer ignores upper");
    cyc();
    rd_lit(0, 5'd3, 2'b00, 1'b0, 64'h2D18, 1'b0, "R3 half xfer ignores upper");
    rd_lit(1, 5'd3, 2'b10, 1'b1, 64'h4009_21FB_5444_2D18, 1'b0, "R6 double compute");
    cyc();
    rd_lit(0, 5'd3, 2'b11, 1'b1, 64'h4009_21FB_5444_2D18, 1'b0, "R6 fmt 11 as double");

    // boundary boxes: a single zero bit in the upper field
    cyc();
    do_wr(5'd4, 2'b10, 64'hFFFE_FFFF_FFFF_1234);
    cyc();
    rd_lit(0, 5'd4, 2'b00, 1'b1, 64'h7E00, 1'b1, "R5 one zero bit half");
    rd_lit(1, 5'd4, 2'b01, 1'b1, 64'h7FC0_0000, 1'b1, "R5 one zero bit single");
    cyc();
    do_wr(5'd31, 2'b10, 64'hFFFF_FFFF_0000_0000);
    cyc();
    do_wr(5'd0, 2'b00, 64'h0000_0000_0000_ABCD);
    rd_lit(0, 5'd31, 2'b01, 1'b1, 64'h0, 1'b0, "R4 single box exact");
    rd_lit(1, 5'd31, 2'b00, 1'b1, 64'h7E00, 1'b1, "R5 half box bits 31:16 zero");
    cyc();
    rd_lit(0, 5'd0, 2'b00, 1'b1, 64'hABCD, 1'b0, "R9 port0 r0");
    rd_lit(1, 5'd31, 2'b10, 1'b0, 64'hFFFF_FFFF_0000_0000, 1'b0, "R9 port1 r31");

    // random mixed traffic against the reference model
    for (int k = 0; k < 400; k++) begin
      cyc();
      if ($urandom_range(0, 1) == 1)
        do_wr(5'($urandom_range(0, 31)), 2'($urandom_range(0, 3)), {$urandom, $urandom});
      rd_mod(0, 5'($urandom_range(0, 31)), 2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)), "R9 random p0");
      rd_mod(1, 5'($urandom_range(0, 31)), 2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)), "R9 random p1");
    end

    repeat (3) cyc();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule